// File: doc/BRIEF.md
# Auxiliary Power Unit Starter Motor Controller

This block decides when the starter motor of an auxiliary power unit is powered. A short press on the start input engages the motor output and holds it on after the press ends. Cranking stops as soon as the unit reports that it runs on its own, or when the shutdown input is raised. It also stops when a cranking window has passed without a successful start, so a unit that fails to light cannot drain the battery.

The cranking window is set by a cycle-counting one-shot that is loaded by each accepted rising edge of start. Its length is the parameter `TIMEOUT_CYCLES`, so a simulation can use a short window while silicon uses one worth many seconds of clock. After a timeout the block stays idle until the start input falls and rises again. A one-cycle `timed_out_o` flag marks an attempt that ended by expiry.

Top module: `starter_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after its release with no start press, `motor_o` and `timed_out_o` are 0.
- R2: A rising edge of `start_i` (low in one sampled cycle, high in the next), sampled while `running_i` and `shutdown_i` are both low, sets `motor_o` to 1 from the cycle after that clock edge.
- R3: Once engaged, `motor_o` stays 1 after `start_i` returns low, until one of the ending conditions in R4, R5 or R6 occurs.
- R4: While `running_i` is 1, `motor_o` is 0 in that same cycle. The attempt is cancelled, and `motor_o` stays 0 after `running_i` falls.
- R5: While `shutdown_i` is 1, `motor_o` is 0 in that same cycle. The attempt is cancelled, and `motor_o` stays 0 after `shutdown_i` falls.
- R6: Without running or shutdown, `motor_o` is 1 for exactly `TIMEOUT_CYCLES` cycles after the edge that accepted the latest start.
- R7: `timed_out_o` is 1 for exactly one cycle: the first cycle in which `motor_o` is 0 after the window expired with the motor still on. An attempt ended by `running_i` or `shutdown_i` gives no pulse.
- R8: A `start_i` held high past a timeout does not start a new attempt. It must go low and then high again.
- R9: A rising edge of `start_i` sampled while `running_i` or `shutdown_i` is high is ignored. Keeping `start_i` high after both inputs fall does not engage the motor.
- R10: A new rising edge of `start_i` while the motor is on reloads the full window. If it coincides with the last window cycle, the reload wins and no `timed_out_o` pulse is given for that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request from the pilot switch, active high |
| shutdown_i | input | 1 | Shutdown request, active high |
| running_i | input | 1 | Unit reports self-sustained running, active high |
| motor_o | output | 1 | Starter motor drive, 1 = powered |
| timed_out_o | output | 1 | One-cycle flag: cranking window expired |

## Verification
Two events can fall into the same cycle. One is the expiry of the cranking window; the other is a stop request or a new start edge. The bench sweeps the cycle in which `running_i` or `shutdown_i` rises, from the first motor cycle to one cycle past expiry. It also sweeps the cycle of a retriggering start edge over the same range, which includes the exact expiry cycle. For each case, the total number of motor-on cycles and of timeout pulses is checked against closed-form counts, and a per-cycle model checks the same run cycle by cycle.

// File: rtl/starter_pkg.sv
package starter_pkg;

  typedef struct packed {
    logic arm;    // accepted start edge: load window, engage
    logic abort;  // running or shutdown: cancel attempt
  } crank_ctl_t;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/crank_timer.sv
module crank_timer
  import starter_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 6000,
  localparam int CNT_W = cnt_width(TIMEOUT_CYCLES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  crank_ctl_t ctl_i,
  output logic       expire_o
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (ctl_i.abort)     cnt_q <= '0;
    else if (ctl_i.arm)       cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - ONE;
  end

  // last window cycle, not overridden by reload or cancel
  assign expire_o = (cnt_q == ONE) & ~ctl_i.arm & ~ctl_i.abort;

endmodule

// File: rtl/motor_latch.sv
module motor_latch
  import starter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  crank_ctl_t ctl_i,
  input  logic       expire_i,
  output logic       latch_o,
  output logic       timed_out_o
);

  logic latch_q, to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      to_q <= expire_i & latch_q;
      if (ctl_i.abort)    latch_q <= 1'b0;
      else if (ctl_i.arm) latch_q <= 1'b1;
      else if (expire_i)  latch_q <= 1'b0;
    end
  end

  assign latch_o     = latch_q;
  assign timed_out_o = to_q;

endmodule

// File: rtl/starter_ctrl.sv
module starter_ctrl
  import starter_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 6000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic shutdown_i,
  input  logic running_i,
  output logic motor_o,
  output logic timed_out_o
);

  logic       start_rise, inhibit, expire, latch;
  crank_ctl_t ctl;

  assign inhibit   = running_i | shutdown_i;
  assign ctl.abort = inhibit;
  assign ctl.arm   = start_rise & ~inhibit;

  rise_detect u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (start_i),
    .rise_o (start_rise)
  );

  crank_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .expire_o (expire)
  );

  motor_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .expire_i    (expire),
    .latch_o     (latch),
    .timed_out_o (timed_out_o)
  );

  // stop requests cut the drive in the same cycle
  assign motor_o = latch & ~inhibit;

endmodule

// File: rtl/starter_ctrl_chk.sv
module starter_ctrl_chk
  import starter_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 6000,
  localparam int CNT_W = cnt_width(TIMEOUT_CYCLES)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic shutdown_i,
  input logic running_i,
  input logic motor_o,
  input logic timed_out_o
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT_CYCLES);

  logic             st_prev_q;
  logic [CNT_W-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_prev_q <= 1'b0;
      since_q   <= LIM;
    end else begin
      st_prev_q <= start_i;
      if (start_i && !st_prev_q && !running_i && !shutdown_i) since_q <= '0;
      else if (since_q != LIM)                                since_q <= since_q + CNT_W'(1);
    end
  end

  // R2
  motor_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(motor_o) |-> ($past(start_i) && !$past(running_i) && !$past(shutdown_i)));

  // R4
  running_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i |=> !motor_o);

  // R5
  shutdown_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |=> !motor_o);

  // R6
  window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    motor_o |-> (since_q < LIM));

  // R7
  pulse_after_motor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timed_out_o |-> (!motor_o && $past(motor_o)));

  // R7
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timed_out_o |=> !timed_out_o);

endmodule

bind starter_ctrl starter_ctrl_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (.*);

// File: tb/tb_starter_ctrl.sv
module tb_starter_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int T = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, shutdown_i = 1'b0, running_i = 1'b0;
  logic motor_o, timed_out_o;

  int n_run = 0, n_fail = 0;
  int hi_cnt = 0, to_cnt = 0;
  bit m_latch = 0, m_prev = 0, m_to = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  starter_ctrl #(.TIMEOUT_CYCLES(T)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .shutdown_i(shutdown_i),
    .running_i(running_i), .motor_o(motor_o), .timed_out_o(timed_out_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive one cycle, check outputs, advance the requirement model
  task automatic step(input bit s, input bit sd, input bit r, input string tag);
    bit inh, arm;
    @(negedge clk);
    start_i = s; shutdown_i = sd; running_i = r;
    #1;
    chk(tag, "motor_o", int'(motor_o), int'(m_latch & !sd & !r));
    chk(tag, "timed_out_o", int'(timed_out_o), int'(m_to));
    hi_cnt += int'(motor_o);
    to_cnt += int'(timed_out_o);
    inh = sd | r;
    arm = s & !m_prev & !inh;
    m_to = 0;
    if (inh) begin m_latch = 0; m_cnt = 0; end
    else if (arm) begin m_latch = 1; m_cnt = T; end
    else if (m_cnt != 0) begin
      if (m_cnt == 1) begin m_to = m_latch; m_latch = 0; end
      m_cnt--;
    end
    m_prev = s;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  task automatic clear_counts();
    hi_cnt = 0; to_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "motor_o in reset", int'(motor_o), 0);
    chk("R1", "timed_out_o in reset", int'(timed_out_o), 0);
    @(negedge clk) rst_ni = 1'b1;
    clear_counts();
    idle(3, "R1");
    chk("R1", "idle high cycles", hi_cnt, 0);

    // R3 R6 R7 R8: press length sweep, incl. hold past timeout
    for (int len = 1; len <= T + 3; len++) begin
      clear_counts();
      for (int i = 0; i < len; i++) step(1, 0, 0, (len > T) ? "R8" : "R3");
      idle(T + 3, "R6");
      chk((len > T) ? "R8" : "R6", "high cycles", hi_cnt, T);
      chk("R7", "timeout pulses", to_cnt, 1);
    end

    // R4: running raised at offset j
    for (int j = 1; j <= T + 1; j++) begin
      clear_counts();
      step(1, 0, 0, "R2");
      for (int c = 1; c <= T + 3; c++) step(0, 0, c >= j, "R4");
      idle(3, "R4");
      chk("R4", "high cycles", hi_cnt, (j - 1 < T) ? j - 1 : T);
      chk("R7", "pulses with running", to_cnt, (j > T) ? 1 : 0);
    end

    // R5: shutdown raised at offset j
    for (int j = 1; j <= T + 1; j++) begin
      clear_counts();
      step(1, 0, 0, "R2");
      for (int c = 1; c <= T + 3; c++) step(0, c >= j, 0, "R5");
      idle(3, "R5");
      chk("R5", "high cycles", hi_cnt, (j - 1 < T) ? j - 1 : T);
      chk("R7", "pulses with shutdown", to_cnt, (j > T) ? 1 : 0);
    end

    // R9: edge during running / shutdown ignored
    for (int v = 0; v < 2; v++) begin
      clear_counts();
      step(1, v == 1, v == 0, "R9");
      step(1, v == 1, v == 0, "R9");
      for (int i = 0; i < 3; i++) step(1, 0, 0, "R9");
      chk("R9", "high cycles after blocked edge", hi_cnt, 0);
      step(0, 0, 0, "R9");
      step(1, 0, 0, "R2");
      idle(T + 3, "R2");
      chk("R2", "high cycles after fresh edge", hi_cnt, T);
    end

    // R10: retrigger at offset k, incl. the expiry cycle
    for (int k = 2; k <= T + 1; k++) begin
      clear_counts();
      step(1, 0, 0, "R10");
      for (int c = 1; c < k; c++) step(0, 0, 0, "R10");
      step(1, 0, 0, "R10");
      idle(T + 3, "R10");
      chk("R10", "high cycles", hi_cnt, (k <= T) ? k + T : 2 * T);
      chk("R10", "timeout pulses", to_cnt, (k <= T) ? 1 : 2);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule